// File: doc/BRIEF.md
# Edge Pairing Hit Buffer for One Timing Channel

This block sits behind the fine-time interpolator of a single channel of a multi-channel time-to-digital converter. Each cycle it may receive one timestamped discriminator edge, marked as leading (rising) or trailing (falling). A two-bit mode input selects which edges are kept. It can keep rising edges only, falling edges only, or every edge as its own word. In the fourth mode it joins each rising edge with the falling edge that follows it into one word. That word holds the rising-edge time and the pulse width, the time over threshold that later stages use for amplitude-walk correction.

Finished words go into a private first-in first-out buffer, 512 entries deep by default. A plain valid/ready handshake empties it. The paired mode handles edges that have no partner. A rising edge that arrives while another is still open closes the older one as an error word. A falling edge with nothing open is dropped and counted. When a write arrives while the buffer is full, the word is lost and a flag records the loss. The next word taken by the reader clears that flag.

Top module: `tdc_pair_buffer`

## Requirements
- R1: Output word layout for the defaults is bits [31:26] channel number (the CHANNEL parameter), [25:24] kind code, [23:8] time, [7:0] width. In mode 0 every rising edge gives one word of kind 00 with its own time and width 0, and falling edges give nothing.
- R2: In mode 1 every falling edge gives one word of kind 01 with its own time and width 0, and rising edges give nothing.
- R3: In mode 2 every edge gives a word: kind 00 for rising and kind 01 for falling, with width 0.
- R4: In mode 3 a falling edge that follows an open rising edge gives one word of kind 10. The word carries the rising-edge time and a width equal to (falling time − rising time) modulo 2^16.
- R5: In mode 3, a width above 255 is stored as 255, and a width of exactly 255 is stored unchanged.
- R6: In mode 3, a rising edge that arrives while another rising edge is open gives a word of kind 11. That word carries the older rising time and width 0, and the new rising edge becomes the open one.
- R7: In mode 3, a falling edge with no open rising edge writes nothing and adds one to an error counter. The counter holds at its maximum (255) and is cleared only by reset.
- R8: Any edge accepted in a mode other than 3 discards an open rising edge, so a later falling edge in mode 3 counts as unpartnered.
- R9: Words leave in write order. A word appears on the output two rising clock edges after the hit is sampled. While valid is high and ready is low, the word and valid stay unchanged. A word is removed on a cycle with both valid and ready high.
- R10: The buffer holds up to 512 words. A word arriving while it is full is discarded and the overflow flag is set. The flag clears on the next removal by the reader, unless another word is discarded in that same cycle.
- R11: Reset empties the buffer, discards any open rising edge, and clears the overflow flag and the error counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Edge mode: 0 rising only, 1 falling only, 2 both, 3 paired |
| hit_valid_i | input | 1 | An edge is presented this cycle |
| hit_lead_i | input | 1 | 1 for a rising edge, 0 for a falling edge |
| hit_time_i | input | 16 | Timestamp of the edge |
| rd_ready_i | input | 1 | Reader accepts the current word |
| rd_valid_o | output | 1 | A word is available |
| rd_word_o | output | 32 | Oldest stored word |
| overflow_o | output | 1 | A word was discarded since the last removal |
| orphan_cnt_o | output | 8 | Saturating count of unpartnered falling edges |

## Verification
The hardest states to reach from the ports are the full buffer and the saturated error counter. Both need hundreds of hits with no reads in between. The bench first runs a table of edge sequences through all four modes, including a width that wraps the 16-bit time, a width of exactly 255 and a width that has to be clamped. It then sends 513 back-to-back hits with ready held low, so the 513th is discarded, and drains the buffer to confirm which words remain. Last, it sends 300 unpartnered falling edges to pin the counter at 255 before a final reset clears everything.

// File: rtl/tdc_pair_pkg.sv
package tdc_pair_pkg;

  typedef enum logic [1:0] {
    MODE_LEAD  = 2'd0,
    MODE_TRAIL = 2'd1,
    MODE_BOTH  = 2'd2,
    MODE_PAIR  = 2'd3
  } edge_mode_e;

  localparam logic [1:0] KIND_LEAD     = 2'b00;
  localparam logic [1:0] KIND_TRAIL    = 2'b01;
  localparam logic [1:0] KIND_PAIR     = 2'b10;
  localparam logic [1:0] KIND_PAIR_ERR = 2'b11;

endpackage

// File: rtl/tdc_edge_pairer.sv
module tdc_edge_pairer
  import tdc_pair_pkg::*;
#(
  parameter int TIME_W  = 16,
  parameter int WIDTH_W = 8,
  parameter int ERR_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  edge_mode_e         mode,
  input  logic               hit_valid,
  input  logic               hit_lead,
  input  logic [TIME_W-1:0]  hit_time,
  output logic               out_valid,
  output logic [1:0]         out_kind,
  output logic [TIME_W-1:0]  out_time,
  output logic [WIDTH_W-1:0] out_width,
  output logic               orphan_evt,
  output logic [ERR_W-1:0]   orphan_cnt
);

  localparam logic [TIME_W-1:0] WIDTH_MAX =
    {{(TIME_W-WIDTH_W){1'b0}}, {WIDTH_W{1'b1}}};

  // Width between two stamps, modulo the time range, clamped to the field.
  function automatic logic [WIDTH_W-1:0] clamp_width(
    input logic [TIME_W-1:0] t_lead,
    input logic [TIME_W-1:0] t_trail
  );
    logic [TIME_W-1:0] diff;
    diff = t_trail - t_lead;
    if (diff > WIDTH_MAX) return '1;
    return diff[WIDTH_W-1:0];
  endfunction

  logic               pend_vld, pend_vld_n;
  logic [TIME_W-1:0]  pend_t, pend_t_n;
  logic               emit_n;
  logic [1:0]         kind_n;
  logic [TIME_W-1:0]  time_n;
  logic [WIDTH_W-1:0] width_n;

  always_comb begin
    emit_n     = 1'b0;
    kind_n     = KIND_LEAD;
    time_n     = hit_time;
    width_n    = '0;
    pend_vld_n = pend_vld;
    pend_t_n   = pend_t;
    orphan_evt = 1'b0;
    if (hit_valid) begin
      if (mode != MODE_PAIR) pend_vld_n = 1'b0;
      case (mode)
        MODE_LEAD: begin
          emit_n = hit_lead;
          kind_n = KIND_LEAD;
        end
        MODE_TRAIL: begin
          emit_n = !hit_lead;
          kind_n = KIND_TRAIL;
        end
        MODE_BOTH: begin
          emit_n = 1'b1;
          kind_n = hit_lead ? KIND_LEAD : KIND_TRAIL;
        end
        MODE_PAIR: begin
          if (hit_lead) begin
            if (pend_vld) begin
              emit_n = 1'b1;
              kind_n = KIND_PAIR_ERR;
              time_n = pend_t;
            end
            pend_vld_n = 1'b1;
            pend_t_n   = hit_time;
          end else if (pend_vld) begin
            emit_n     = 1'b1;
            kind_n     = KIND_PAIR;
            time_n     = pend_t;
            width_n    = clamp_width(pend_t, hit_time);
            pend_vld_n = 1'b0;
          end else begin
            orphan_evt = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld   <= 1'b0;
      pend_t     <= '0;
      out_valid  <= 1'b0;
      out_kind   <= KIND_LEAD;
      out_time   <= '0;
      out_width  <= '0;
      orphan_cnt <= '0;
    end else begin
      pend_vld  <= pend_vld_n;
      pend_t    <= pend_t_n;
      out_valid <= emit_n;
      out_kind  <= kind_n;
      out_time  <= time_n;
      out_width <= width_n;
      if (orphan_evt && !(&orphan_cnt)) orphan_cnt <= orphan_cnt + ERR_W'(1);
    end
  end

endmodule

// File: rtl/tdc_hit_fifo.sv
module tdc_hit_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 512,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          wr_drop,
  output logic          rd_pop,
  output logic [CW-1:0] fill,
  output logic          overflow
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push, is_full;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign is_full  = (fill == CW'(DEPTH));
  assign push     = wr_en && !is_full;
  assign wr_drop  = wr_en && is_full;
  assign rd_valid = (fill != '0);
  assign rd_pop   = rd_valid && rd_ready;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill     <= '0;
      overflow <= 1'b0;
    end else begin
      if (push)   wr_ptr <= bump(wr_ptr);
      if (rd_pop) rd_ptr <= bump(rd_ptr);
      case ({push, rd_pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
      if (wr_drop)     overflow <= 1'b1;
      else if (rd_pop) overflow <= 1'b0;
    end
  end

endmodule

// File: rtl/tdc_pair_buffer.sv
module tdc_pair_buffer
  import tdc_pair_pkg::*;
#(
  parameter int CH_W    = 6,
  parameter int CHANNEL = 0,
  parameter int TIME_W  = 16,
  parameter int WIDTH_W = 8,
  parameter int DEPTH   = 512,
  parameter int ERR_W   = 8,
  localparam int WORD_W = CH_W + 2 + TIME_W + WIDTH_W,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              hit_valid_i,
  input  logic              hit_lead_i,
  input  logic [TIME_W-1:0] hit_time_i,
  input  logic              rd_ready_i,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              overflow_o,
  output logic [ERR_W-1:0]  orphan_cnt_o
);

  localparam logic [CH_W-1:0] CH_CODE = CH_W'(CHANNEL);

  // Named internal events, observed by the bound checker.
  logic               pair_valid;
  logic [1:0]         pair_kind;
  logic [TIME_W-1:0]  pair_time;
  logic [WIDTH_W-1:0] pair_width;
  logic               orphan_evt;
  logic               fifo_drop;
  logic               fifo_pop;
  logic [FILL_W-1:0]  fill_cnt;
  logic [WORD_W-1:0]  packed_word;

  tdc_edge_pairer #(
    .TIME_W (TIME_W),
    .WIDTH_W(WIDTH_W),
    .ERR_W  (ERR_W)
  ) u_pairer (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (edge_mode_e'(mode_i)),
    .hit_valid (hit_valid_i),
    .hit_lead  (hit_lead_i),
    .hit_time  (hit_time_i),
    .out_valid (pair_valid),
    .out_kind  (pair_kind),
    .out_time  (pair_time),
    .out_width (pair_width),
    .orphan_evt(orphan_evt),
    .orphan_cnt(orphan_cnt_o)
  );

  assign packed_word = {CH_CODE, pair_kind, pair_time, pair_width};

  tdc_hit_fifo #(
    .DW   (WORD_W),
    .DEPTH(DEPTH)
  ) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pair_valid),
    .wr_data (packed_word),
    .rd_ready(rd_ready_i),
    .rd_valid(rd_valid_o),
    .rd_data (rd_word_o),
    .wr_drop (fifo_drop),
    .rd_pop  (fifo_pop),
    .fill    (fill_cnt),
    .overflow(overflow_o)
  );

endmodule

// File: rtl/tdc_pair_buffer_chk.sv
module tdc_pair_buffer_chk #(
  parameter int WORD_W  = 32,
  parameter int TIME_W  = 16,
  parameter int WIDTH_W = 8,
  parameter int ERR_W   = 8,
  parameter int DEPTH   = 512,
  parameter int FILL_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic [WORD_W-1:0] rd_word_o,
  input logic              overflow_o,
  input logic [ERR_W-1:0]  orphan_cnt_o,
  input logic              orphan_evt,
  input logic              fifo_drop,
  input logic              fifo_pop,
  input logic [FILL_W-1:0] fill_cnt
);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_word_o)));

  // R10
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= FILL_W'(DEPTH));

  // R10
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_drop |=> overflow_o);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop && !fifo_drop) |=> !overflow_o);

  // R7
  orphan_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    orphan_evt |=> ((orphan_cnt_o == ($past(orphan_cnt_o) + ERR_W'(1))) ||
                    (&$past(orphan_cnt_o))));

  // R7
  orphan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !orphan_evt |=> $stable(orphan_cnt_o));

  // R6
  err_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && (rd_word_o[WIDTH_W+TIME_W +: 2] == 2'b11))
      |-> (rd_word_o[WIDTH_W-1:0] == '0));

endmodule

bind tdc_pair_buffer tdc_pair_buffer_chk #(
  .WORD_W (WORD_W),
  .TIME_W (TIME_W),
  .WIDTH_W(WIDTH_W),
  .ERR_W  (ERR_W),
  .DEPTH  (DEPTH),
  .FILL_W (FILL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_valid_o  (rd_valid_o),
  .rd_ready_i  (rd_ready_i),
  .rd_word_o   (rd_word_o),
  .overflow_o  (overflow_o),
  .orphan_cnt_o(orphan_cnt_o),
  .orphan_evt  (orphan_evt),
  .fifo_drop   (fifo_drop),
  .fifo_pop    (fifo_pop),
  .fill_cnt    (fill_cnt)
);

// File: tb/tb_tdc_pair_buffer.sv
module tb_tdc_pair_buffer;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 21;

  typedef struct packed {
    logic [1:0]  mode;
    logic        lead;
    logic [15:0] t;
    logic        ev;
    logic [1:0]  k;
    logic [15:0] et;
    logic [7:0]  ew;
  } vec_t;

  // mode, rising, time | word expected, kind, time, width
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 1'b1, 16'd100,   1'b1, 2'd0, 16'd100,   8'd0},   // R1
    '{2'd0, 1'b0, 16'd110,   1'b0, 2'd0, 16'd0,     8'd0},   // R1
    '{2'd1, 1'b1, 16'd200,   1'b0, 2'd0, 16'd0,     8'd0},   // R2
    '{2'd1, 1'b0, 16'd210,   1'b1, 2'd1, 16'd210,   8'd0},   // R2
    '{2'd2, 1'b1, 16'd300,   1'b1, 2'd0, 16'd300,   8'd0},   // R3
    '{2'd2, 1'b0, 16'd305,   1'b1, 2'd1, 16'd305,   8'd0},   // R3
    '{2'd3, 1'b1, 16'd1000,  1'b0, 2'd0, 16'd0,     8'd0},   // R4
    '{2'd3, 1'b0, 16'd1025,  1'b1, 2'd2, 16'd1000,  8'd25},  // R4
    '{2'd3, 1'b0, 16'd1030,  1'b0, 2'd0, 16'd0,     8'd0},   // R7
    '{2'd3, 1'b1, 16'd2000,  1'b0, 2'd0, 16'd0,     8'd0},   // R6
    '{2'd3, 1'b1, 16'd2010,  1'b1, 2'd3, 16'd2000,  8'd0},   // R6
    '{2'd3, 1'b0, 16'd2015,  1'b1, 2'd2, 16'd2010,  8'd5},   // R6
    '{2'd3, 1'b1, 16'd3000,  1'b0, 2'd0, 16'd0,     8'd0},   // R5
    '{2'd3, 1'b0, 16'd3300,  1'b1, 2'd2, 16'd3000,  8'd255}, // R5
    '{2'd3, 1'b1, 16'd4000,  1'b0, 2'd0, 16'd0,     8'd0},   // R5
    '{2'd3, 1'b0, 16'd4255,  1'b1, 2'd2, 16'd4000,  8'd255}, // R5
    '{2'd3, 1'b1, 16'd65530, 1'b0, 2'd0, 16'd0,     8'd0},   // R4
    '{2'd3, 1'b0, 16'd20,    1'b1, 2'd2, 16'd65530, 8'd26},  // R4
    '{2'd3, 1'b1, 16'd5000,  1'b0, 2'd0, 16'd0,     8'd0},   // R8
    '{2'd2, 1'b0, 16'd5100,  1'b1, 2'd1, 16'd5100,  8'd0},   // R8
    '{2'd3, 1'b0, 16'd5200,  1'b0, 2'd0, 16'd0,     8'd0}    // R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        hit_valid_i = 1'b0;
  logic        hit_lead_i = 1'b0;
  logic [15:0] hit_time_i = '0;
  logic        rd_ready_i = 1'b0;
  logic        rd_valid_o;
  logic [31:0] rd_word_o;
  logic        overflow_o;
  logic [7:0]  orphan_cnt_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdc_pair_buffer #(.CHANNEL(5)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .hit_valid_i (hit_valid_i),
    .hit_lead_i  (hit_lead_i),
    .hit_time_i  (hit_time_i),
    .rd_ready_i  (rd_ready_i),
    .rd_valid_o  (rd_valid_o),
    .rd_word_o   (rd_word_o),
    .overflow_o  (overflow_o),
    .orphan_cnt_o(orphan_cnt_o)
  );

  function automatic logic [31:0] word_of(input logic [1:0] k,
                                          input logic [15:0] t,
                                          input logic [7:0] w);
    return {6'd5, k, t, w};
  endfunction

  task automatic chk(input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pop_one();
    rd_ready_i = 1'b1;
    @(negedge clk);
    rd_ready_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    hit_valid_i = 1'b0;
    rd_ready_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] exp_q[$];
    logic [31:0] first_w, last_w;
    int          got;

    do_reset();
    // R11 reset state
    chk("R11 valid after reset", 64'(rd_valid_o), 64'(0));
    chk("R11 overflow after reset", 64'(overflow_o), 64'(0));
    chk("R11 counter after reset", 64'(orphan_cnt_o), 64'(0));

    // Table walk: all hits back to back, reader stalled
    for (int i = 0; i < NVEC; i++) begin
      mode_i      = VEC[i].mode;
      hit_lead_i  = VEC[i].lead;
      hit_time_i  = VEC[i].t;
      hit_valid_i = 1'b1;
      if (VEC[i].ev) exp_q.push_back(word_of(VEC[i].k, VEC[i].et, VEC[i].ew));
      @(negedge clk);
    end
    hit_valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);

    // R9 stall: word held while ready is low
    for (int s = 0; s < 3; s++) begin
      chk("R9 held valid", 64'(rd_valid_o), 64'(1));
      chk("R9 held word", 64'(rd_word_o), 64'(exp_q[0]));
      @(negedge clk);
    end

    // R1 R2 R3 R4 R5 R6 R8 words in order
    for (int j = 0; j < 11; j++) begin
      chk("R9 valid during drain", 64'(rd_valid_o), 64'(1));
      chk("R1-R8 table word", 64'(rd_word_o), 64'(exp_q[j]));
      pop_one();
    end
    chk("R8 no extra words", 64'(rd_valid_o), 64'(0));
    chk("R7 R8 orphan count", 64'(orphan_cnt_o), 64'(2));
    chk("R10 no overflow yet", 64'(overflow_o), 64'(0));

    // R9 latency: hit sampled at edge k, visible after edge k+1
    mode_i = 2'd0; hit_lead_i = 1'b1; hit_time_i = 16'd777; hit_valid_i = 1'b1;
    @(negedge clk);
    hit_valid_i = 1'b0;
    chk("R9 not yet visible", 64'(rd_valid_o), 64'(0));
    @(negedge clk);
    chk("R9 visible after two edges", 64'(rd_valid_o), 64'(1));
    chk("R9 latency word", 64'(rd_word_o), 64'(word_of(2'd0, 16'd777, 8'd0)));
    pop_one();

    // R10 fill past capacity
    mode_i = 2'd2; hit_lead_i = 1'b1;
    for (int i = 0; i < 513; i++) begin
      hit_time_i  = 16'(i);
      hit_valid_i = 1'b1;
      @(negedge clk);
    end
    hit_valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 overflow set", 64'(overflow_o), 64'(1));
    first_w = rd_word_o;
    chk("R10 oldest kept", 64'(first_w), 64'(word_of(2'd0, 16'd0, 8'd0)));
    pop_one();
    chk("R10 overflow cleared by read", 64'(overflow_o), 64'(0));
    got = 1;
    last_w = first_w;
    for (int i = 0; i < 600; i++) begin
      if (rd_valid_o) begin
        last_w = rd_word_o;
        got++;
        pop_one();
      end
    end
    chk("R10 stored count", 64'(got), 64'(512));
    chk("R10 last kept word", 64'(last_w), 64'(word_of(2'd0, 16'd511, 8'd0)));

    // R7 saturation
    mode_i = 2'd3; hit_lead_i = 1'b0;
    for (int i = 0; i < 300; i++) begin
      hit_time_i  = 16'(i);
      hit_valid_i = 1'b1;
      @(negedge clk);
    end
    hit_valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 counter saturates", 64'(orphan_cnt_o), 64'(255));
    chk("R7 orphans write nothing", 64'(rd_valid_o), 64'(0));

    // R11 open rising edge and counter cleared by reset
    hit_lead_i = 1'b1; hit_time_i = 16'd9000; hit_valid_i = 1'b1;
    @(negedge clk);
    hit_valid_i = 1'b0;
    do_reset();
    chk("R11 counter cleared", 64'(orphan_cnt_o), 64'(0));
    mode_i = 2'd3; hit_lead_i = 1'b0; hit_time_i = 16'd9010; hit_valid_i = 1'b1;
    @(negedge clk);
    hit_valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R11 open edge discarded", 64'(rd_valid_o), 64'(0));
    chk("R11 later falling counted", 64'(orphan_cnt_o), 64'(1));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule